// File: doc/BRIEF.md
# Presettable Up/Down Binary Counter Stage

This block is one synchronous binary counter stage. It is four bits wide by default and set by a parameter. A two-bit select input picks one of four operations on each rising clock edge:
- parallel load from the data input,
- count up,
- count down,
- hold.

Counting is gated by an active-low carry input. An active-low carry output reports that the stage is about to roll over, so several stages can be chained on one clock into a wider counter. No gates are needed between them.

The carry output is combinational. It goes low in two cases. The first is whenever the load operation is selected. The second is when the stage sits at its terminal value in a count mode while its carry input is active. Because the signal propagates through the chain within a single clock period, every stage of a cascade updates on the same edge. An active-high synchronous reset clears the count, and it is provided only to initialise the stage.

Top module: `updn_ctr4`

## Requirements
- R1: While `rst` is high at a rising clock edge, `q` becomes zero, whatever the other inputs are.
- R2: With `sel` = 2'b00 (load), `q` takes the value of `din` at the rising edge. A change of `din` between edges leaves `q` unchanged.
- R3: With `sel` = 2'b01 (up) and `cin_n` low, `q` increases by one at each edge and wraps from all ones to zero.
- R4: With `sel` = 2'b10 (down) and `cin_n` low, `q` decreases by one at each edge and wraps from zero to all ones.
- R5: With `sel` = 2'b11 (hold), `q` keeps its value whatever `cin_n` and `din` are.
- R6: In up or down mode with `cin_n` high, `q` keeps its value.
- R7: `cout_n` is low for as long as `sel` = 2'b00, whatever the count and `cin_n` are.
- R8: `cout_n` is low in up mode when `q` is all ones and `cin_n` is low. It is also low in down mode when `q` is zero and `cin_n` is low. Otherwise, in those two modes, it is high.
- R9: `cout_n` is high in hold mode.
- R10: Three stages chained from `cout_n` to `cin_n`, with the first stage's `cin_n` tied low, form a 12-bit counter that increments and decrements with carries and borrows crossing every stage boundary on a single edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high clear |
| sel | input | 2 | Operation: 00 load, 01 up, 10 down, 11 hold |
| din | input | WIDTH | Parallel load value |
| cin_n | input | 1 | Active-low count enable from the previous stage |
| q | output | WIDTH | Current count |
| cout_n | output | 1 | Active-low carry to the next stage |

## Verification
The clocked properties assume that `sel`, `din` and `cin_n` are settled around each rising edge and carry no unknown values once reset has been applied. The bench therefore changes every input on the falling edge only. It also holds `rst` high from time zero through the first edges, so no property looks back past reset. The cascade shares one `sel` across all stages, which keeps each stage in a legal mode on every edge.

// File: rtl/updn_ctr4.sv
module updn_ctr4 #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       sel,
  input  logic [WIDTH-1:0] din,
  input  logic             cin_n,
  output logic [WIDTH-1:0] q,
  output logic             cout_n
);
  localparam logic [1:0]       M_LOAD = 2'b00;
  localparam logic [1:0]       M_UP   = 2'b01;
  localparam logic [1:0]       M_DN   = 2'b10;
  localparam logic [1:0]       M_HOLD = 2'b11;
  localparam logic [WIDTH-1:0] TOP    = '1;
  localparam logic [WIDTH-1:0] BOT    = '0;
  localparam logic [WIDTH-1:0] ONE    = {{(WIDTH-1){1'b0}}, 1'b1};

  logic load, up, dn, en;
  assign load = (sel == M_LOAD);
  assign up   = (sel == M_UP);
  assign dn   = (sel == M_DN);
  assign en   = ~cin_n;

  always_ff @(posedge clk) begin
    if (rst)            q <= '0;
    else if (load)      q <= din;
    else if (up && en)  q <= q + ONE;
    else if (dn && en)  q <= q - ONE;
  end

  assign cout_n = ~(load | (en & ((up & (q == TOP)) | (dn & (q == BOT)))));

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (q == BOT)); // R1
  AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (rst)
    (sel == M_LOAD) |=> (q == $past(din))); // R2
  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (sel == M_UP && !cin_n) |=> (q == $past(q) + ONE)); // R3
  AST_DN_STEP: assert property (@(posedge clk) disable iff (rst)
    (sel == M_DN && !cin_n) |=> (q == $past(q) - ONE)); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (sel == M_HOLD) |=> $stable(q)); // R5
  AST_GATED_STABLE: assert property (@(posedge clk) disable iff (rst)
    ((sel == M_UP || sel == M_DN) && cin_n) |=> $stable(q)); // R6
  AST_LOAD_CARRY_LOW: assert property (@(posedge clk) disable iff (rst)
    (sel == M_LOAD) |-> !cout_n); // R7
  AST_HOLD_CARRY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sel == M_HOLD) |-> cout_n); // R9
endmodule

// File: tb/updn_ctr4_tb_top.sv
module updn_ctr4_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 14;
  // {sel[1:0], cin_n, din[3:0], cout_n expected before edge, q expected after edge}
  localparam logic [11:0] VEC [NV] = '{
    {2'b00, 1'b1, 4'hE, 1'b0, 4'hE},
    {2'b01, 1'b0, 4'h0, 1'b1, 4'hF},
    {2'b01, 1'b0, 4'h0, 1'b0, 4'h0},
    {2'b01, 1'b1, 4'h0, 1'b1, 4'h0},
    {2'b10, 1'b0, 4'h0, 1'b0, 4'hF},
    {2'b10, 1'b0, 4'h0, 1'b1, 4'hE},
    {2'b10, 1'b1, 4'h0, 1'b1, 4'hE},
    {2'b11, 1'b0, 4'h3, 1'b1, 4'hE},
    {2'b00, 1'b1, 4'h0, 1'b0, 4'h0},
    {2'b11, 1'b1, 4'h0, 1'b1, 4'h0},
    {2'b00, 1'b0, 4'hF, 1'b0, 4'hF},
    {2'b11, 1'b0, 4'h0, 1'b1, 4'hF},
    {2'b01, 1'b1, 4'h0, 1'b1, 4'hF},
    {2'b10, 1'b0, 4'h0, 1'b1, 4'hE}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] sel = 2'b11;
  logic [3:0] din = 4'h0;
  logic cin_n = 1'b1;
  logic [3:0] q;
  logic cout_n;

  logic [1:0] c_sel = 2'b11;
  logic [11:0] c_din = 12'h000;
  logic [11:0] c_q;
  logic [3:0] cn;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  updn_ctr4 #(.WIDTH(4)) dut_i (
    .clk(clk), .rst(rst), .sel(sel), .din(din), .cin_n(cin_n), .q(q), .cout_n(cout_n)
  );

  assign cn[0] = 1'b0;
  for (genvar g = 0; g < 3; g++) begin : g_stage
    updn_ctr4 #(.WIDTH(4)) stg_i (
      .clk(clk), .rst(rst), .sel(c_sel), .din(c_din[4*g +: 4]), .cin_n(cn[g]),
      .q(c_q[4*g +: 4]), .cout_n(cn[g+1])
    );
  end

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string q_tag(input logic [1:0] s, input logic c);
    if (s == 2'b00) return "R2 load";
    if (s == 2'b11) return "R5 hold";
    if (c) return "R6 gated";
    return (s == 2'b01) ? "R3 up" : "R4 down";
  endfunction

  function automatic string c_tag(input logic [1:0] s);
    if (s == 2'b00) return "R7 carry in load";
    if (s == 2'b11) return "R9 carry in hold";
    return "R8 carry at terminal";
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset clears", {8'h0, q}, 12'h000);
    check("R1 cascade reset", c_q, 12'h000);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sel = VEC[i][11:10];
      cin_n = VEC[i][9];
      din = VEC[i][8:5];
      #1;
      check(c_tag(sel), {11'h0, cout_n}, {11'h0, VEC[i][4]});
      @(posedge clk);
      #1;
      check(q_tag(VEC[i][11:10], VEC[i][9]), {8'h0, q}, {8'h0, VEC[i][3:0]});
    end

    // R2: din moves between edges without effect
    @(negedge clk); sel = 2'b00; din = 4'h5;
    @(posedge clk); #1;
    check("R2 load 5", {8'h0, q}, 12'h005);
    @(negedge clk); sel = 2'b11; din = 4'hA; #1;
    check("R2 din change between edges", {8'h0, q}, 12'h005);

    // R8: carry inactive when cin_n high even at terminal count
    @(negedge clk); sel = 2'b00; din = 4'hF;
    @(posedge clk);
    @(negedge clk); sel = 2'b01; cin_n = 1'b1; #1;
    check("R8 terminal but cin_n high", {11'h0, cout_n}, 12'h001);
    cin_n = 1'b0; #1;
    check("R8 terminal with cin_n low", {11'h0, cout_n}, 12'h000);

    // R1: reset mid-run overrides count mode
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1 reset over count", {8'h0, q}, 12'h000);
    @(negedge clk); rst = 1'b0; sel = 2'b11;

    // R10: cascade
    @(negedge clk); c_sel = 2'b00; c_din = 12'h0FF;
    @(posedge clk);
    @(negedge clk); c_sel = 2'b01;
    @(posedge clk); #1;
    check("R10 up across two stages", c_q, 12'h100);
    @(negedge clk); c_sel = 2'b10;
    @(posedge clk); #1;
    check("R10 borrow across two stages", c_q, 12'h0FF);
    @(negedge clk); c_sel = 2'b00; c_din = 12'hFFF;
    @(posedge clk);
    @(negedge clk); c_sel = 2'b01; #1;
    check("R10 chain carry out at FFF", {11'h0, cn[3]}, 12'h000);
    @(posedge clk); #1;
    check("R10 wrap FFF to 000", c_q, 12'h000);
    @(negedge clk); #1;
    check("R10 chain carry idle at 000", {11'h0, cn[3]}, 12'h001);
    c_sel = 2'b10; #1;
    check("R10 chain borrow out at 000", {11'h0, cn[3]}, 12'h000);
    @(posedge clk); #1;
    check("R10 wrap 000 to FFF", c_q, 12'hFFF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule